// File: doc/BRIEF.md
# ADC Result Message Router

This block sits between an analog-to-digital converter and the host-facing result queues. Each raw sample arrives on a valid/ready stream together with a 3-bit destination index and a bypass flag. The selected converter resolution left-justifies the sample into a 16-bit result. The block prepends a 4-bit routing header to form a 20-bit result message. The message then takes one of two paths:

- **Direct path (bypass flag set).** The message goes straight to the result FIFO that its index names.
- **Side path (bypass flag clear).** The message leaves on an outbound side stream towards an external filter. The filter later hands a message of the same format back on an inbound side stream, and the block routes it to a FIFO by its index.

There are six result FIFOs, each four entries deep. Each FIFO raises a request line towards the host or DMA engine for as long as it holds data. The head entry is visible on a read bus, and the host removes it with a per-FIFO pop strobe.

The three streams follow these back-pressure rules:

- A transfer happens on a rising clock edge where valid and ready are both high.
- `raw_ready` depends on the offered header. For a side-path message it follows `side_out_ready`. For a direct-path message it is low while a returned message is being offered, and low while the target FIFO is full.
- `side_in_ready` is low only while the returned message targets a full FIFO.
- A message whose index names no FIFO is always accepted, then discarded, and it sets a sticky error flag.

Top module: `result_router`

## Requirements
- R1: The result is the raw sample left-justified into 16 bits, with all lower bits zero. `res_mode` 2'b00 places raw[7:0] at result[15:8]. 2'b01 places raw[9:0] at result[15:6]. 2'b10 and 2'b11 place raw[11:0] at result[15:4]. Raw bits above the selected resolution have no effect.
- R2: A message is 20 bits: bit 19 is the bypass flag, bits 18:16 the FIFO index, bits 15:0 the result. A raw sample with bypass 0 appears combinationally on `side_out_msg` with `side_out_valid` high, and `raw_ready` equals `side_out_ready`. Such a sample never writes a FIFO.
- R3: A raw sample with bypass 1 and index 0..5 is written into FIFO `index` when it is accepted.
- R4: An accepted returned message with index 0..5 is written into FIFO `index`. Its bit 19 has no effect.
- R5: While `side_in_valid` is high, a bypass-1 raw sample is not accepted. The returned message is written first, and the stalled sample follows once `side_in_valid` drops.
- R6: A message on either path with index 6 or 7 is accepted and writes no FIFO. It sets `err_flag`, which stays high until reset.
- R7: Each FIFO holds 4 entries. A message that targets a full FIFO is held off (`raw_ready` or `side_in_ready` low). Messages for other FIFOs are unaffected.
- R8: `host_req[k]` is high exactly while FIFO k holds data. `host_data[16k+15:16k]` shows its oldest entry. `host_pop[k]` removes that entry in first-in first-out order, and a pop of an empty FIFO has no effect.
- R9: After reset all FIFOs are empty, `host_req` is 0 and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_mode | input | 2 | Converter resolution select |
| raw_valid | input | 1 | Raw sample offered |
| raw_ready | output | 1 | Raw sample accepted this edge |
| raw_bypass | input | 1 | 1 = direct to FIFO, 0 = via side path |
| raw_idx | input | 3 | Destination FIFO index |
| raw_data | input | 12 | Right-justified raw sample |
| side_out_valid | output | 1 | Outbound side message valid |
| side_out_ready | input | 1 | Filter accepts outbound message |
| side_out_msg | output | 20 | Outbound message |
| side_in_valid | input | 1 | Returned message valid |
| side_in_ready | output | 1 | Returned message accepted |
| side_in_msg | input | 20 | Returned message |
| host_pop | input | 6 | Per-FIFO pop strobe |
| host_req | output | 6 | Per-FIFO service request |
| host_data | output | 96 | Head entry of each FIFO, 16 bits per FIFO |
| err_flag | output | 1 | Sticky bad-index flag |

## Verification
The bench sweeps every 12-bit sample value under all four resolution codes with garbage in the unused high bits. A wrong shift or an unmasked bit there shows up as a corrupted result. It issues simultaneous direct and returned messages to one FIFO. A design that let the direct path through would lose one message or store them in the wrong order. It fills a FIFO to its depth and checks that only that FIFO's traffic is held off and that the data drains in order. It also sends indices 6 and 7 down both paths. A design that decoded them modulo six or truncated the index would raise a request on a real FIFO and leave the error flag clear.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RAW_W = 12;
  localparam int RES_W = 16;
  localparam int IDX_W = 3;
  localparam int HDR_W = IDX_W + 1;
  localparam int MSG_W = HDR_W + RES_W;

  typedef enum logic [1:0] {
    RES_8  = 2'b00,
    RES_10 = 2'b01,
    RES_12 = 2'b10,
    RES_12B = 2'b11
  } res_mode_e;

  typedef struct packed {
    logic             bypass;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] res;
  } msg_t;
endpackage

// File: rtl/rr_align.sv
module rr_align
  import rr_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [RAW_W-1:0] raw,
  output logic [RES_W-1:0] res
);
  localparam int PAD8  = RES_W - 8;
  localparam int PAD10 = RES_W - 10;
  localparam int PAD12 = RES_W - 12;

  always_comb begin
    case (mode)
      RES_8:   res = {raw[7:0], {PAD8{1'b0}}};
      RES_10:  res = {raw[9:0], {PAD10{1'b0}}};
      default: res = {raw[11:0], {PAD12{1'b0}}};
    endcase
  end
endmodule

// File: rtl/rr_fifo.sv
module rr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R7
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (pop && empty && !push) |=> empty); // R8
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n) (push && !pop) |=> !empty); // R8
endmodule

// File: rtl/rr_dispatch.sv
module rr_dispatch
  import rr_pkg::*;
#(
  parameter int NUM_FIFO = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raw_valid,
  input  msg_t                raw_msg,
  output logic                raw_ready,
  output logic                side_out_valid,
  input  logic                side_out_ready,
  output msg_t                side_out_msg,
  input  logic                side_in_valid,
  input  msg_t                side_in_msg,
  output logic                side_in_ready,
  input  logic [NUM_FIFO-1:0] full,
  output logic [NUM_FIFO-1:0] push,
  output logic [RES_W-1:0]    push_data,
  output logic                err_flag
);
  localparam int NSLOT = 1 << IDX_W;

  logic [NSLOT-1:0] full_ext;
  logic ret_ok, dir_ok, dir_blk, ret_fire, dir_fire, err_q;

  assign full_ext = NSLOT'(full);
  assign ret_ok   = (side_in_msg.idx < IDX_W'(NUM_FIFO));
  assign dir_ok   = (raw_msg.idx < IDX_W'(NUM_FIFO));

  assign side_in_ready = !(ret_ok && full_ext[side_in_msg.idx]);
  assign ret_fire      = side_in_valid && side_in_ready;

  assign dir_blk   = side_in_valid || (dir_ok && full_ext[raw_msg.idx]);
  assign dir_fire  = raw_valid && raw_msg.bypass && !dir_blk;
  assign raw_ready = raw_msg.bypass ? !dir_blk : side_out_ready;

  assign side_out_valid = raw_valid && !raw_msg.bypass;
  assign side_out_msg   = raw_msg;

  generate
    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_push
      assign push[k] = (ret_fire && ret_ok && (side_in_msg.idx == IDX_W'(k))) ||
                       (dir_fire && dir_ok && (raw_msg.idx == IDX_W'(k)));
    end
  endgenerate

  assign push_data = ret_fire ? side_in_msg.res : raw_msg.res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if ((ret_fire && !ret_ok) || (dir_fire && !dir_ok)) err_q <= 1'b1;
  end
  assign err_flag = err_q;

  AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (side_in_valid && raw_valid && raw_msg.bypass) |-> !raw_ready); // R5
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(push)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q); // R6
  AST_BAD_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (side_in_valid && !ret_ok) |-> (push == '0)); // R6
  AST_RET_FLAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (side_in_msg.bypass && ret_ok && !full_ext[side_in_msg.idx]) |-> side_in_ready); // R4
  AST_SIDE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (raw_valid && !raw_msg.bypass && !side_in_valid) |-> (push == '0)); // R2
endmodule

// File: rtl/result_router.sv
module result_router
  import rr_pkg::*;
#(
  parameter int NUM_FIFO   = 6,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                res_mode,
  input  logic                      raw_valid,
  output logic                      raw_ready,
  input  logic                      raw_bypass,
  input  logic [IDX_W-1:0]          raw_idx,
  input  logic [RAW_W-1:0]          raw_data,
  output logic                      side_out_valid,
  input  logic                      side_out_ready,
  output logic [MSG_W-1:0]          side_out_msg,
  input  logic                      side_in_valid,
  output logic                      side_in_ready,
  input  logic [MSG_W-1:0]          side_in_msg,
  input  logic [NUM_FIFO-1:0]       host_pop,
  output logic [NUM_FIFO-1:0]       host_req,
  output logic [NUM_FIFO*RES_W-1:0] host_data,
  output logic                      err_flag
);
  logic [RES_W-1:0]    aligned, push_data;
  logic [NUM_FIFO-1:0] push, full, empty;
  msg_t                raw_msg, out_msg;

  rr_align u_align (
    .mode (res_mode),
    .raw  (raw_data),
    .res  (aligned)
  );

  assign raw_msg = '{bypass: raw_bypass, idx: raw_idx, res: aligned};

  rr_dispatch #(.NUM_FIFO(NUM_FIFO)) u_dispatch (
    .clk            (clk),
    .rst_n          (rst_n),
    .raw_valid      (raw_valid),
    .raw_msg        (raw_msg),
    .raw_ready      (raw_ready),
    .side_out_valid (side_out_valid),
    .side_out_ready (side_out_ready),
    .side_out_msg   (out_msg),
    .side_in_valid  (side_in_valid),
    .side_in_msg    (msg_t'(side_in_msg)),
    .side_in_ready  (side_in_ready),
    .full           (full),
    .push           (push),
    .push_data      (push_data),
    .err_flag       (err_flag)
  );

  assign side_out_msg = out_msg;

  generate
    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_fifo
      rr_fifo #(.DEPTH(FIFO_DEPTH), .W(RES_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push[k]),
        .pop   (host_pop[k]),
        .wdata (push_data),
        .rdata (host_data[k*RES_W +: RES_W]),
        .full  (full[k]),
        .empty (empty[k])
      );
      assign host_req[k] = !empty[k];
    end
  endgenerate

  AST_ALIGN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (side_out_valid && res_mode == RES_8) |-> (side_out_msg[7:0] == 8'h00)); // R1
  AST_HDR_CARRIED: assert property (@(posedge clk) disable iff (!rst_n) side_out_valid |-> (side_out_msg[MSG_W-2:RES_W] == raw_idx)); // R2
endmodule

// File: tb/result_router_tb_top.sv
`timescale 1ns/1ps
module result_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  res_mode = 2'b10;
  logic        raw_valid = 1'b0, raw_bypass = 1'b1;
  logic [2:0]  raw_idx = 3'd0;
  logic [11:0] raw_data = 12'd0;
  logic        raw_ready, side_out_valid, side_in_ready, err_flag;
  logic        side_out_ready = 1'b1, side_in_valid = 1'b0;
  logic [19:0] side_out_msg, side_in_msg = 20'd0;
  logic [5:0]  host_pop = 6'd0, host_req;
  logic [95:0] host_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  result_router dut_i (
    .clk(clk), .rst_n(rst_n), .res_mode(res_mode),
    .raw_valid(raw_valid), .raw_ready(raw_ready), .raw_bypass(raw_bypass),
    .raw_idx(raw_idx), .raw_data(raw_data),
    .side_out_valid(side_out_valid), .side_out_ready(side_out_ready), .side_out_msg(side_out_msg),
    .side_in_valid(side_in_valid), .side_in_ready(side_in_ready), .side_in_msg(side_in_msg),
    .host_pop(host_pop), .host_req(host_req), .host_data(host_data), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_res(input logic [1:0] m, input logic [11:0] v);
    case (m)
      2'b00:   return {v[7:0], 8'h00};
      2'b01:   return {v[9:0], 6'h00};
      default: return {v[11:0], 4'h0};
    endcase
  endfunction

  function automatic logic [15:0] slot(input int k);
    return host_data[k*16 +: 16];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One raw transfer; entry and exit at a negedge with valid low.
  task automatic send_raw(input bit byp, input logic [2:0] idx, input logic [11:0] d, input string tag);
    raw_bypass = byp; raw_idx = idx; raw_data = d; raw_valid = 1'b1;
    #0.5;
    chk(raw_ready === 1'b1, tag, raw_ready, 1);
    @(posedge clk);
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic send_ret(input logic [19:0] m, input string tag);
    side_in_msg = m; side_in_valid = 1'b1;
    #0.5;
    chk(side_in_ready === 1'b1, tag, side_in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    side_in_valid = 1'b0;
  endtask

  task automatic pop_chk(input int k, input logic [15:0] exp, input string tag);
    chk(host_req[k] === 1'b1, tag, host_req, 6'(1 << k));
    chk(slot(k) === exp, tag, slot(k), exp);
    host_pop[k] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_pop = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(host_req === 6'd0, "R9 reset req", host_req, 0);
    chk(err_flag === 1'b0, "R9 reset err", err_flag, 0);

    // R1/R3/R8: every sample, every resolution code, rotating FIFOs
    for (int m = 0; m < 4; m++) begin
      res_mode = 2'(m);
      for (int v = 0; v < 4096; v++) begin
        int k = v % 6;
        send_raw(1'b1, 3'(k), 12'(v), "R3 direct accept");
        pop_chk(k, expect_res(2'(m), 12'(v)), "R1 aligned result");
        chk(host_req === 6'd0, "R8 drained", host_req, 0);
      end
    end

    // R2: side path header and back-pressure
    res_mode = 2'b01;
    for (int i = 0; i < 8; i++) begin
      raw_bypass = 1'b0; raw_idx = 3'(i); raw_data = 12'(12'h5A3 + i * 97);
      side_out_ready = 1'b0; raw_valid = 1'b1;
      #0.5;
      chk(side_out_valid === 1'b1, "R2 side valid", side_out_valid, 1);
      chk(side_out_msg === {1'b0, 3'(i), expect_res(2'b01, raw_data)}, "R2 side msg",
          side_out_msg, {1'b0, 3'(i), expect_res(2'b01, raw_data)});
      chk(raw_ready === 1'b0, "R2 ready follows side", raw_ready, 0);
      side_out_ready = 1'b1;
      #0.5;
      chk(raw_ready === 1'b1, "R2 ready follows side", raw_ready, 1);
      @(posedge clk);
      @(negedge clk);
      raw_valid = 1'b0;
      chk(host_req === 6'd0 && err_flag === 1'b0, "R2 no FIFO write", {host_req, err_flag}, 0);
    end

    // R4: returned messages route by index, bit 19 ignored
    for (int i = 0; i < 6; i++) begin
      send_ret({1'(i & 1), 3'(i), 16'(16'hC100 + i)}, "R4 ret accept");
      pop_chk(i, 16'(16'hC100 + i), "R4 returned routed");
    end

    // R5: returned message wins over direct
    raw_bypass = 1'b1; raw_idx = 3'd1; raw_data = 12'hABC; res_mode = 2'b10; raw_valid = 1'b1;
    side_in_msg = {1'b0, 3'd1, 16'h1234}; side_in_valid = 1'b1;
    #0.5;
    chk(raw_ready === 1'b0, "R5 direct stalled", raw_ready, 0);
    chk(side_in_ready === 1'b1, "R5 return taken", side_in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    side_in_valid = 1'b0;
    #0.5;
    chk(raw_ready === 1'b1, "R5 direct resumes", raw_ready, 1);
    @(posedge clk);
    @(negedge clk);
    raw_valid = 1'b0;
    pop_chk(1, 16'h1234, "R5 order first");
    pop_chk(1, 16'hABC0, "R5 order second");

    // R7: fill FIFO 2, others unaffected, in-order drain
    for (int i = 0; i < 4; i++) send_raw(1'b1, 3'd2, 12'(i + 1), "R7 fill");
    raw_bypass = 1'b1; raw_idx = 3'd2; raw_valid = 1'b1;
    #0.5;
    chk(raw_ready === 1'b0, "R7 full holds direct", raw_ready, 0);
    raw_valid = 1'b0;
    side_in_msg = {1'b0, 3'd2, 16'hFFFF}; side_in_valid = 1'b1;
    #0.5;
    chk(side_in_ready === 1'b0, "R7 full holds return", side_in_ready, 0);
    side_in_valid = 1'b0;
    send_raw(1'b1, 3'd3, 12'h777, "R7 other FIFO free");
    for (int i = 0; i < 4; i++) pop_chk(2, expect_res(2'b10, 12'(i + 1)), "R7 in order");
    pop_chk(3, 16'h7770, "R7 other FIFO data");

    // R8: pop on empty ignored
    host_pop[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_pop = '0;
    chk(host_req === 6'd0, "R8 empty pop", host_req, 0);
    send_raw(1'b1, 3'd0, 12'h321, "R8 push after empty pop");
    pop_chk(0, 16'h3210, "R8 head after empty pop");
    chk(host_req[0] === 1'b0, "R8 single entry", host_req, 0);

    // R6: bad indices on both paths
    send_raw(1'b1, 3'd6, 12'h111, "R6 bad direct accepted");
    chk(host_req === 6'd0, "R6 no write", host_req, 0);
    chk(err_flag === 1'b1, "R6 err set", err_flag, 1);
    repeat (5) @(negedge clk);
    chk(err_flag === 1'b1, "R6 err sticky", err_flag, 1);
    do_reset();
    @(negedge clk);
    chk(err_flag === 1'b0, "R9 err cleared", err_flag, 0);
    send_ret({1'b1, 3'd7, 16'h2222}, "R6 bad return accepted");
    chk(host_req === 6'd0, "R6 no write ret", host_req, 0);
    chk(err_flag === 1'b1, "R6 err set ret", err_flag, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule